// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the write-command state machine of a byte-wide parallel NOR flash, together with a small behavioural storage array. The host drives single-cycle write strobes (`wr_en` with `addr` and `wr_data`) and single-cycle read strobes (`rd_en` with `addr`). A six-write unlock sequence selects one of two erase operations. Chip erase starts at once. Sector erase opens an acceptance window. During that window, more sector commands can be queued, and any other write cancels the request.

When erasure runs, the engine makes two passes over the array. The first pass writes zeros to every location of each selected sector. The second pass writes all ones to the same locations. Each selected location costs a programmable number of clock cycles in each pass. While the window is open or the erase is running, reads return a status byte instead of array data. That byte carries a busy flag, a toggle bit, and a bit that tells whether the window has closed. When the erase finishes, the block returns to plain array reads. Writes made during the erase have no effect.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is in read mode. A read returns, on `rd_data` in the cycle after `rd_en`, the array byte at index `addr[6:0]`. Before any erase, byte i holds the low 8 bits of (i*37+11). Reset cancels any open window, and the toggle phase of bit 6 restarts at 0.
- R2: The unlock steps are 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, and 0x55 at 0x2AA. A write with the wrong byte or the wrong address at any step returns the block to read mode, and nothing is erased. In read mode, any write other than 0xAA at 0x555 is ignored.
- R3: If the sixth write is 0x10 at 0x555, the whole array is erased, and the erase starts with no window. The first status read after that write already shows bit 3 = 1. Afterwards every byte reads 0xFF.
- R4: If the sixth write is 0x30, the window opens for the sector given by `addr[6:4]` (8 sectors of 16 bytes). While the window is open, status reads show bit 7 = 0 and bit 3 = 0.
- R5: Each further 0x30 write inside the window adds the sector at `addr[6:4]`, in any order, and restarts the window timer. Erasure begins TIMEOUT cycles after the last accepted 0x30 write. Only the queued sectors become 0xFF.
- R6: Any write other than 0x30 inside the window closes it and returns the block to read mode at once, and no sector is erased.
- R7: While the erase runs, status reads show bit 7 = 0 and bit 3 = 1, and bits 5:4 and 2:0 are 0.
- R8: Bit 6 of the status byte inverts on every status read. Array reads do not advance it.
- R9: Writes during the erase are ignored, including a complete chip-erase sequence. When the erase finishes, the block returns to read mode.
- R10: The erase makes a zero pass and then a ones pass. Each location of a queued sector takes ERASE_DLY cycles in each pass, and each other location takes 1 cycle. This puts a k-sector erase at 2*(16*k*ERASE_DLY + 16*(8-k)) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Bus address for reads and writes |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_data | output | 8 | Array byte or status byte, valid the cycle after `rd_en` |

## Verification
The bench builds the block with TIMEOUT = 40 and ERASE_DLY = 4. At these values the window can be read inside its lifetime, restarted, and let expire within a few dozen cycles. A full chip erase completes in about a thousand cycles. With the short delay, one status read can fall after a single pass would have ended but before two passes end. This makes the two-pass duration visible from the ports. The bench can also queue three sectors out of order and confirm that the unqueued sectors keep their initial pattern.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] KEY_A      = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY_B      = 8'h55;
  localparam logic [BYTE_W-1:0] CODE_SETUP = 8'h80;
  localparam logic [BYTE_W-1:0] CODE_CHIP  = 8'h10;
  localparam logic [BYTE_W-1:0] CODE_SECT  = 8'h30;

  localparam int ADDR_KEY_A = 'h555;
  localparam int ADDR_KEY_B = 'h2AA;

  // status bit positions seen by software
  localparam int SB_DONE = 7;
  localparam int SB_TOG  = 6;
  localparam int SB_TMO  = 3;

  typedef enum logic [2:0] {
    ST_READ, ST_K1, ST_K2, ST_SETUP, ST_K3, ST_K4, ST_WIN, ST_BUSY
  } cmd_st_e;
endpackage

// File: rtl/fes_cmd_fsm.sv
module fes_cmd_fsm
  import fes_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NSEC    = 8,
  parameter int SEC_W   = 3,
  parameter int SEC_LSB = 4,
  parameter int TIMEOUT = 2500
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                eng_done,
  output logic                busy,
  output logic                window,
  output logic                eng_start,
  output logic [NSEC-1:0]     sec_mask
);
  localparam int TMR_W = $clog2(TIMEOUT + 1);

  cmd_st_e          st, st_n;
  logic [TMR_W-1:0] tmr;

  logic hit_a, hit_b, tmo, chip_cmd, sect_cmd;
  logic [SEC_W-1:0] sec_sel;

  assign hit_a    = (addr == ADDR_W'(ADDR_KEY_A));
  assign hit_b    = (addr == ADDR_W'(ADDR_KEY_B));
  assign tmo      = (tmr == TMR_W'(TIMEOUT - 1));
  assign sec_sel  = addr[SEC_LSB +: SEC_W];
  assign chip_cmd = wr_en && (st == ST_K4) && hit_a && (wr_data == CODE_CHIP);
  assign sect_cmd = wr_en && ((st == ST_K4) || (st == ST_WIN)) && (wr_data == CODE_SECT);

  always_comb begin
    st_n      = st;
    eng_start = 1'b0;
    case (st)
      ST_READ:  if (wr_en && hit_a && wr_data == KEY_A) st_n = ST_K1;
      ST_K1:    if (wr_en) st_n = (hit_b && wr_data == KEY_B) ? ST_K2 : ST_READ;
      ST_K2:    if (wr_en) st_n = (hit_a && wr_data == CODE_SETUP) ? ST_SETUP : ST_READ;
      ST_SETUP: if (wr_en) st_n = (hit_a && wr_data == KEY_A) ? ST_K3 : ST_READ;
      ST_K3:    if (wr_en) st_n = (hit_b && wr_data == KEY_B) ? ST_K4 : ST_READ;
      ST_K4: begin
        if (chip_cmd) begin
          st_n      = ST_BUSY;
          eng_start = 1'b1;
        end else if (sect_cmd) begin
          st_n = ST_WIN;
        end else if (wr_en) begin
          st_n = ST_READ;
        end
      end
      ST_WIN: begin
        if (wr_en) begin
          st_n = sect_cmd ? ST_WIN : ST_READ;
        end else if (tmo) begin
          st_n      = ST_BUSY;
          eng_start = 1'b1;
        end
      end
      ST_BUSY:  if (eng_done) st_n = ST_READ;
      default:  st_n = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_READ;
      tmr      <= '0;
      sec_mask <= '0;
    end else begin
      st <= st_n;
      // each accepted sector command restarts the window
      if (sect_cmd) tmr <= '0;
      else if (st == ST_WIN) tmr <= tmr + 1'b1;

      if (chip_cmd) sec_mask <= '1;
      else if (sect_cmd) sec_mask[sec_sel] <= 1'b1;
      else if (st_n == ST_READ) sec_mask <= '0;
    end
  end

  assign busy   = (st == ST_BUSY);
  assign window = (st == ST_WIN);
endmodule

// File: rtl/fes_erase_engine.sv
module fes_erase_engine
  import fes_pkg::*;
#(
  parameter int NSEC      = 8,
  parameter int SEC_BYTES = 16,
  parameter int ERASE_DLY = 100,
  parameter int LOC_W     = $clog2(NSEC * SEC_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NSEC-1:0]   sec_mask,
  input  logic              rd_en,
  input  logic [LOC_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_q,
  output logic              done
);
  localparam int DEPTH = NSEC * SEC_BYTES;
  localparam int OFF_W = $clog2(SEC_BYTES);
  localparam int DLY_W = $clog2(ERASE_DLY + 1);

  logic [BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = BYTE_W'(i * 37 + 11);
  end

  logic             run, pass;
  logic [LOC_W-1:0] loc;
  logic [DLY_W-1:0] dly;
  logic             in_mask, last_loc, dly_end, step, wr;

  assign in_mask  = sec_mask[loc[LOC_W-1:OFF_W]];
  assign last_loc = (loc == LOC_W'(DEPTH - 1));
  assign dly_end  = (dly == DLY_W'(ERASE_DLY - 1));
  assign wr       = run && in_mask && dly_end;
  assign step     = run && (!in_mask || dly_end);
  assign done     = step && last_loc && pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      pass <= 1'b0;
      loc  <= '0;
      dly  <= '0;
    end else if (start) begin
      run  <= 1'b1;
      pass <= 1'b0;
      loc  <= '0;
      dly  <= '0;
    end else if (run) begin
      if (step) begin
        dly <= '0;
        loc <= last_loc ? '0 : loc + 1'b1;
        if (last_loc) begin
          if (pass) run <= 1'b0;
          else      pass <= 1'b1;
        end
      end else begin
        dly <= dly + 1'b1;
      end
    end
  end

  // simple dual-port array: engine writes, bus reads
  always_ff @(posedge clk) begin
    if (wr) mem[loc] <= pass ? '1 : '0;
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NSEC      = 8,
  parameter int SEC_BYTES = 16,
  parameter int TIMEOUT   = 2500,
  parameter int ERASE_DLY = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data
);
  localparam int LOC_W = $clog2(NSEC * SEC_BYTES);
  localparam int OFF_W = $clog2(SEC_BYTES);
  localparam int SEC_W = $clog2(NSEC);

  logic            busy, window, eng_start, eng_done;
  logic [NSEC-1:0] sec_mask;
  logic [7:0]      mem_q, stat_n, stat_q;
  logic            tog, stat_sel, stat_mode;

  fes_cmd_fsm #(
    .ADDR_W(ADDR_W), .NSEC(NSEC), .SEC_W(SEC_W), .SEC_LSB(OFF_W), .TIMEOUT(TIMEOUT)
  ) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .eng_done(eng_done), .busy(busy), .window(window),
    .eng_start(eng_start), .sec_mask(sec_mask)
  );

  fes_erase_engine #(
    .NSEC(NSEC), .SEC_BYTES(SEC_BYTES), .ERASE_DLY(ERASE_DLY), .LOC_W(LOC_W)
  ) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .sec_mask(sec_mask),
    .rd_en(rd_en), .rd_addr(addr[LOC_W-1:0]), .rd_q(mem_q), .done(eng_done)
  );

  assign stat_mode = busy || window;

  always_comb begin
    stat_n          = '0;
    stat_n[SB_DONE] = 1'b0;
    stat_n[SB_TOG]  = tog;
    stat_n[SB_TMO]  = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog      <= 1'b0;
      stat_sel <= 1'b0;
      stat_q   <= '0;
    end else if (rd_en) begin
      stat_sel <= stat_mode;
      stat_q   <= stat_n;
      if (stat_mode) tog <= ~tog;
    end
  end

  assign rd_data = stat_sel ? stat_q : mem_q;
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int NSEC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [7:0]      wr_data,
  input logic            rd_en,
  input logic [7:0]      rd_data,
  input logic            busy,
  input logic            window,
  input logic            eng_done,
  input logic [NSEC-1:0] sec_mask
);
  p_win_status_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && window) |=> (!rd_data[7] && !rd_data[3]));

  p_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (window && wr_en && wr_data != 8'h30) |=> (!window && !busy));

  p_idle_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !window) |-> (sec_mask == '0));

  p_busy_status_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (!rd_data[7] && rd_data[3]));

  p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(sec_mask));

  p_done_r9: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> !busy);
endmodule

bind flash_erase_seq fes_checker #(.NSEC(NSEC)) u_fes_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .rd_data(rd_data), .busy(busy), .window(window), .eng_done(eng_done),
  .sec_mask(sec_mask)
);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int TMO = 40;
  localparam int DLY = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;

  always #10 clk = ~clk;

  flash_erase_seq #(
    .ADDR_W(12), .NSEC(8), .SEC_BYTES(16), .TIMEOUT(TMO), .ERASE_DLY(DLY)
  ) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  typedef enum logic [2:0] {K_WR, K_RD, K_ST, K_WAIT, K_ERA} kind_e;
  typedef struct packed {
    kind_e       k;
    logic [11:0] a;
    logic [7:0]  d;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 82;
  localparam vec_t VEC [NV] = '{
    // R1 initial pattern
    '{K_RD, 12'h000, 8'h00, 4'd1}, '{K_RD, 12'h07F, 8'h00, 4'd1}, '{K_RD, 12'h035, 8'h00, 4'd1},
    // R2 wrong byte at step 2
    '{K_WR, 12'h555, 8'hAA, 4'd2}, '{K_WR, 12'h2AA, 8'h54, 4'd2}, '{K_WR, 12'h555, 8'h80, 4'd2},
    '{K_WR, 12'h555, 8'hAA, 4'd2}, '{K_WR, 12'h2AA, 8'h55, 4'd2}, '{K_WR, 12'h020, 8'h30, 4'd2},
    '{K_RD, 12'h020, 8'h00, 4'd2}, '{K_WAIT, 12'd100, 8'h00, 4'd2}, '{K_RD, 12'h020, 8'h00, 4'd2},
    // R2 wrong address at step 5
    '{K_WR, 12'h555, 8'hAA, 4'd2}, '{K_WR, 12'h2AA, 8'h55, 4'd2}, '{K_WR, 12'h555, 8'h80, 4'd2},
    '{K_WR, 12'h555, 8'hAA, 4'd2}, '{K_WR, 12'h2AB, 8'h55, 4'd2}, '{K_WR, 12'h010, 8'h30, 4'd2},
    '{K_WAIT, 12'd100, 8'h00, 4'd2}, '{K_RD, 12'h010, 8'h00, 4'd2},
    // R6 abort inside the window
    '{K_WR, 12'h555, 8'hAA, 4'd6}, '{K_WR, 12'h2AA, 8'h55, 4'd6}, '{K_WR, 12'h555, 8'h80, 4'd6},
    '{K_WR, 12'h555, 8'hAA, 4'd6}, '{K_WR, 12'h2AA, 8'h55, 4'd6}, '{K_WR, 12'h030, 8'h30, 4'd6},
    '{K_ST, 12'h000, 8'h00, 4'd4}, '{K_WR, 12'h000, 8'hF0, 4'd6}, '{K_RD, 12'h030, 8'h00, 4'd6},
    '{K_WAIT, 12'd100, 8'h00, 4'd6}, '{K_RD, 12'h030, 8'h00, 4'd6}, '{K_WR, 12'h030, 8'h30, 4'd2},
    '{K_WAIT, 12'd100, 8'h00, 4'd2}, '{K_RD, 12'h031, 8'h00, 4'd2},
    // R5 queue sectors 5, 1, 7 with timer restarts; R9 writes ignored while busy
    '{K_WR, 12'h555, 8'hAA, 4'd5}, '{K_WR, 12'h2AA, 8'h55, 4'd5}, '{K_WR, 12'h555, 8'h80, 4'd5},
    '{K_WR, 12'h555, 8'hAA, 4'd5}, '{K_WR, 12'h2AA, 8'h55, 4'd5}, '{K_WR, 12'h05A, 8'h30, 4'd5},
    '{K_ST, 12'h000, 8'h00, 4'd4}, '{K_WR, 12'h012, 8'h30, 4'd5}, '{K_ST, 12'h000, 8'h00, 4'd5},
    '{K_WR, 12'h07F, 8'h30, 4'd5}, '{K_WAIT, 12'd30, 8'h00, 4'd5}, '{K_ST, 12'h000, 8'h00, 4'd5},
    '{K_WAIT, 12'd20, 8'h00, 4'd7}, '{K_ST, 12'h000, 8'h08, 4'd7}, '{K_ST, 12'h000, 8'h08, 4'd8},
    '{K_WR, 12'h555, 8'hAA, 4'd9}, '{K_WR, 12'h2AA, 8'h55, 4'd9}, '{K_WR, 12'h555, 8'h80, 4'd9},
    '{K_WR, 12'h555, 8'hAA, 4'd9}, '{K_WR, 12'h2AA, 8'h55, 4'd9}, '{K_WR, 12'h555, 8'h10, 4'd9},
    '{K_ST, 12'h000, 8'h08, 4'd9}, '{K_WAIT, 12'd1200, 8'h00, 4'd9},
    '{K_ERA, 12'h000, 8'd1, 4'd5}, '{K_ERA, 12'h000, 8'd5, 4'd5}, '{K_ERA, 12'h000, 8'd7, 4'd5},
    '{K_RD, 12'h010, 8'h00, 4'd5}, '{K_RD, 12'h01F, 8'h00, 4'd5}, '{K_RD, 12'h050, 8'h00, 4'd5},
    '{K_RD, 12'h05F, 8'h00, 4'd5}, '{K_RD, 12'h070, 8'h00, 4'd5}, '{K_RD, 12'h07F, 8'h00, 4'd5},
    '{K_RD, 12'h000, 8'h00, 4'd9}, '{K_RD, 12'h020, 8'h00, 4'd9}, '{K_RD, 12'h040, 8'h00, 4'd9},
    '{K_RD, 12'h060, 8'h00, 4'd9},
    // R10 single sector: still busy after one pass would end, done after two
    '{K_WR, 12'h555, 8'hAA, 4'd10}, '{K_WR, 12'h2AA, 8'h55, 4'd10}, '{K_WR, 12'h555, 8'h80, 4'd10},
    '{K_WR, 12'h555, 8'hAA, 4'd10}, '{K_WR, 12'h2AA, 8'h55, 4'd10}, '{K_WR, 12'h000, 8'h30, 4'd10},
    '{K_WAIT, 12'd300, 8'h00, 4'd10}, '{K_ST, 12'h000, 8'h08, 4'd10},
    '{K_WAIT, 12'd150, 8'h00, 4'd10}, '{K_ERA, 12'h000, 8'd0, 4'd10},
    '{K_RD, 12'h000, 8'h00, 4'd10}, '{K_RD, 12'h00F, 8'h00, 4'd10}
  };

  int checks = 0;
  int errors = 0;
  int st_reads = 0;
  bit finished = 1'b0;
  logic [7:0] model [128];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rd_data, model[a[6:0]]);
  endtask

  task automatic do_st(input logic [7:0] base, input string tag);
    logic [7:0] exp;
    exp = base;
    exp[6] = st_reads[0];
    @(negedge clk);
    rd_en = 1'b1; addr = '0;
    @(negedge clk);
    rd_en = 1'b0;
    st_reads++;
    check(tag, rd_data, exp);
  endtask

  task automatic erase_model(input int sec);
    for (int j = 0; j < 16; j++) model[sec * 16 + j] = 8'hFF;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] s0, s1;
    for (int i = 0; i < 128; i++) model[i] = 8'(i * 37 + 11);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VEC[v].r, v);
      case (VEC[v].k)
        K_WR:   do_wr(VEC[v].a, VEC[v].d);
        K_RD:   do_rd(VEC[v].a, tag);
        K_ST:   do_st(VEC[v].d, tag);
        K_WAIT: repeat (int'(VEC[v].a)) @(posedge clk);
        K_ERA:  erase_model(int'(VEC[v].d));
        default: ;
      endcase
    end

    // R1: reset inside an open window cancels it and restarts the toggle phase
    do_wr(12'h555, 8'hAA); do_wr(12'h2AA, 8'h55); do_wr(12'h555, 8'h80);
    do_wr(12'h555, 8'hAA); do_wr(12'h2AA, 8'h55); do_wr(12'h020, 8'h30);
    do_st(8'h00, "R4 window before reset");
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    st_reads = 0;
    do_rd(12'h020, "R1 read mode after reset");
    repeat (100) @(posedge clk);
    do_rd(12'h021, "R1 no erase after reset");

    // R3: chip erase starts at once; R8: consecutive status reads differ in bit 6
    do_wr(12'h555, 8'hAA); do_wr(12'h2AA, 8'h55); do_wr(12'h555, 8'h80);
    do_wr(12'h555, 8'hAA); do_wr(12'h2AA, 8'h55); do_wr(12'h555, 8'h10);
    @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; s0 = rd_data;
    @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; s1 = rd_data;
    check("R3 busy at once after chip command", s0, 8'h08);
    check("R8 second status read toggles", s1, 8'h48);
    repeat (1500) @(posedge clk);
    for (int s = 0; s < 8; s++) erase_model(s);
    do_rd(12'h000, "R3 chip erased first");
    do_rd(12'h045, "R3 chip erased middle");
    do_rd(12'h07F, "R3 chip erased last");

    finish_run();
  end
endmodule